// File: doc/BRIEF.md
# Register-Controlled Module Clock Divider

This block derives a module clock from one of several reference sources. Each source arrives as a pulse train of clock enables in a single fast system clock domain. A single 32-bit control word sets everything. It holds a run bit, a source index, a power-of-two pre-scale exponent `p` and a linear divisor code `m`. The output period, counted in ticks of the chosen source, is `2^p * (m+1)`, so the block only ever divides. The total ratio runs from 1 to 128.

The block drives a level output, `clk_out`, and a one-cycle strobe, `rise_stb`, that marks the start of each output period. Software may rewrite the control word at any time. A changed source, exponent or divisor code is taken up only at the next period start, so a period is never cut short. Clearing the run bit lets a high phase run to its end and then parks the output low with the counters cleared.

Top module: `modclk_div`

## Requirements
- R1: After reset, `rd_data` is 0 and `clk_out` and `rise_stb` are both 0.
- R2: A write stores the run bit at bit 31, the source index at bits 24 upward (`SEL_W` bits wide, 2 by default), `p` at bits 17:16 and `m` at bits 3:0. `rd_data` returns these fields in the same positions on the cycle after the write. Every other bit reads 0, whatever was written to it.
- R3: While running, the output period is `N = 2^p * (m+1)` ticks of the selected source.
- R4: In each period, `clk_out` is high for `ceil(N/2)` ticks and low for `floor(N/2)` ticks. With `N = 1` it stays high.
- R5: Only ticks on `ref_tick[sel]` advance the divider. Ticks on other sources, and cycles with no tick, leave `clk_out` unchanged.
- R6: A rewrite of `sel`, `p` or `m` while running does not touch the period in progress. The new values apply from the next period start onward.
- R7: Clearing the run bit while `clk_out` is high keeps it high until the high phase ends, then holds it low. Clearing it while `clk_out` is low stops the block at the next cycle. Either way the counters return to zero, so a later enable starts a fresh period.
- R8: `rise_stb` is high for exactly one cycle at each period start, together with `clk_out` high. It is never high at any other time.
- R9: When the run bit is set from the stopped state, the first tick of the selected source starts a period. `clk_out` goes high and `rise_stb` pulses in the cycle after that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Control word readback |
| ref_tick | input | 2^SEL_W | One enable pulse train per reference source |
| clk_out | output | 1 | Divided module clock level |
| rise_stb | output | 1 | One-cycle pulse at each period start |

## Verification
A wrong period or phase counter shows up at `clk_out` on the very next tick of the selected source. A bad reload instead appears at the next period boundary, as a period of the wrong length or as a strobe that is missing or misplaced. If the active configuration were taken from the register mid-period, the run-in-progress length would change within at most one period after the write. A divider that failed to stop would produce a low level where a fresh start should give a high level and a strobe on the first tick after re-enabling. Every case is therefore judged tick by tick at the outputs, with ticks on the other sources placed between the selected ticks.

// File: rtl/modclk_pkg.sv
package modclk_pkg;

    // Control word field placement
    localparam int EN_BIT    = 31;
    localparam int SEL_LSB   = 24;
    localparam int SEL_MAX_W = 4;
    localparam int P_LSB     = 16;
    localparam int P_W       = 2;
    localparam int M_LSB     = 0;
    localparam int M_W       = 4;

    // Pre-scale counter width: largest exponent is 2^P_W - 1
    localparam int PC_W      = (1 << P_W) - 1;
    // Wide enough to hold the largest total ratio (2^PC_W * 2^M_W) plus one
    localparam int RATIO_W   = M_W + PC_W + 1;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_st_e;

    typedef struct packed {
        logic                 en;
        logic [SEL_MAX_W-1:0] sel;
        logic [P_W-1:0]       p;
        logic [M_W-1:0]       m;
    } mc_cfg_t;

    // Total division ratio in reference ticks
    function automatic logic [RATIO_W-1:0] ratio_of(input logic [P_W-1:0] p,
                                                     input logic [M_W-1:0] m);
        logic [RATIO_W-1:0] r;
        r = RATIO_W'(m) + RATIO_W'(1);
        return r << p;
    endfunction

    // Length of the high phase: half the ratio, rounded up
    function automatic logic [RATIO_W-1:0] high_len_of(input logic [RATIO_W-1:0] r);
        return (r + RATIO_W'(1)) >> 1;
    endfunction

endpackage

// File: rtl/modclk_cfg_reg.sv
module modclk_cfg_reg
    import modclk_pkg::*;
#(
    parameter int SEL_W = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output mc_cfg_t     cfg
);

    localparam logic [31:0] FIELD_MASK =
          (32'h1 << EN_BIT)
        | (((32'h1 << SEL_W) - 32'h1) << SEL_LSB)
        | (((32'h1 << P_W)   - 32'h1) << P_LSB)
        | (((32'h1 << M_W)   - 32'h1) << M_LSB);

    mc_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            cfg_q.en  <= wr_data[EN_BIT];
            cfg_q.sel <= SEL_MAX_W'(wr_data[SEL_LSB +: SEL_W]);
            cfg_q.p   <= wr_data[P_LSB +: P_W];
            cfg_q.m   <= wr_data[M_LSB +: M_W];
        end
    end

    always_comb begin
        rd_data                   = '0;
        rd_data[EN_BIT]           = cfg_q.en;
        rd_data[SEL_LSB +: SEL_W] = cfg_q.sel[SEL_W-1:0];
        rd_data[P_LSB +: P_W]     = cfg_q.p;
        rd_data[M_LSB +: M_W]     = cfg_q.m;
    end

    assign cfg = cfg_q;

    // R2: written fields come back, unassigned bits read zero
    p_write_readback_r2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rd_data == ($past(wr_data) & FIELD_MASK)));

    // R2: without a write the word holds
    p_hold_no_write_r2: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(rd_data));

endmodule

// File: rtl/modclk_src_sel.sv
module modclk_src_sel
    import modclk_pkg::*;
#(
    parameter int NUM_SRC = 4
) (
    input  logic [NUM_SRC-1:0]   ticks,
    input  logic [SEL_MAX_W-1:0] sel,
    output logic                 tick
);

    logic [NUM_SRC-1:0] hit;

    // An AND-OR tree; an index beyond the source count selects nothing
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        assign hit[i] = ticks[i] && (sel == SEL_MAX_W'(i));
    end

    assign tick = |hit;

endmodule

// File: rtl/modclk_divcore.sv
module modclk_divcore
    import modclk_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  mc_cfg_t              cfg,
    input  logic                 tick,
    output logic [SEL_MAX_W-1:0] sel_use,
    output logic                 clk_out,
    output logic                 rise_stb
);

    run_st_e              st_q;
    logic [SEL_MAX_W-1:0] act_sel;
    logic [P_W-1:0]       act_p;
    logic [M_W-1:0]       act_m;
    logic [PC_W-1:0]      pc_q;
    logic [M_W-1:0]       mc_q;
    logic                 out_q;
    logic                 stb_q;

    logic [PC_W:0]        pc_max;
    logic                 pc_last;
    logic                 mc_last;
    logic                 wrap;
    logic [RATIO_W-1:0]   ratio;
    logic [RATIO_W-1:0]   hi_len;
    logic [RATIO_W-1:0]   pos;
    logic [RATIO_W-1:0]   pos_nx;
    logic                 stop_now;

    always_comb begin
        pc_max   = ((PC_W+1)'(1) << act_p) - (PC_W+1)'(1);
        pc_last  = ({1'b0, pc_q} == pc_max);
        mc_last  = (mc_q == act_m);
        wrap     = pc_last && mc_last;
        ratio    = ratio_of(act_p, act_m);
        hi_len   = high_len_of(ratio);
        pos      = (RATIO_W'(mc_q) << act_p) | RATIO_W'(pc_q);
        pos_nx   = pos + RATIO_W'(1);
        stop_now = !cfg.en && (!out_q || (tick && (pos_nx >= hi_len)));
        sel_use  = (st_q == ST_RUN) ? act_sel : cfg.sel;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            act_sel <= '0;
            act_p   <= '0;
            act_m   <= '0;
            pc_q    <= '0;
            mc_q    <= '0;
            out_q   <= 1'b0;
            stb_q   <= 1'b0;
        end else begin
            stb_q <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (cfg.en && tick) begin
                        st_q    <= ST_RUN;
                        act_sel <= cfg.sel;
                        act_p   <= cfg.p;
                        act_m   <= cfg.m;
                        pc_q    <= '0;
                        mc_q    <= '0;
                        out_q   <= 1'b1;
                        stb_q   <= 1'b1;
                    end
                end
                ST_RUN: begin
                    if (stop_now) begin
                        st_q  <= ST_IDLE;
                        pc_q  <= '0;
                        mc_q  <= '0;
                        out_q <= 1'b0;
                    end else if (tick) begin
                        if (wrap) begin
                            act_sel <= cfg.sel;
                            act_p   <= cfg.p;
                            act_m   <= cfg.m;
                            pc_q    <= '0;
                            mc_q    <= '0;
                            out_q   <= 1'b1;
                            stb_q   <= 1'b1;
                        end else begin
                            if (pc_last) begin
                                pc_q <= '0;
                                mc_q <= mc_q + M_W'(1);
                            end else begin
                                pc_q <= pc_q + PC_W'(1);
                            end
                            out_q <= (pos_nx < hi_len);
                        end
                    end
                end
            endcase
        end
    end

    assign clk_out  = out_q;
    assign rise_stb = stb_q;

    // R7: a stopped divider drives low
    p_idle_low_r7: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE) |-> !out_q);

    // R7: cleared run bit during the low phase stops on the next cycle
    p_stop_in_low_r7: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_RUN && !cfg.en && !out_q) |=> (st_q == ST_IDLE));

    // R8: the strobe only accompanies a high output
    p_stb_with_high_r8: assert property (@(posedge clk) disable iff (rst)
        stb_q |-> out_q);

    // R8: every rising output edge is flagged
    p_rise_flagged_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(out_q) |-> stb_q);

    // R6: active settings change only together with a period start
    p_cfg_at_boundary_r6: assert property (@(posedge clk) disable iff (rst)
        !stb_q |-> $stable({act_sel, act_p, act_m}));

    // R3: position stays inside the period
    p_pos_in_period_r3: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_RUN) |-> (pos < ratio));

    // R5: without a selected tick the output level holds and no strobe appears
    p_tick_gates_r5: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(out_q) && !stb_q));

endmodule

// File: rtl/modclk_div.sv
module modclk_div
    import modclk_pkg::*;
#(
    parameter int SEL_W = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [31:0]           wr_data,
    output logic [31:0]           rd_data,
    input  logic [(1<<SEL_W)-1:0] ref_tick,
    output logic                  clk_out,
    output logic                  rise_stb
);

    localparam int NUM_SRC = 1 << SEL_W;

    mc_cfg_t              cfg;
    logic [SEL_MAX_W-1:0] sel_use;
    logic                 tick;

    modclk_cfg_reg #(
        .SEL_W (SEL_W)
    ) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .cfg     (cfg)
    );

    modclk_src_sel #(
        .NUM_SRC (NUM_SRC)
    ) u_sel (
        .ticks (ref_tick),
        .sel   (sel_use),
        .tick  (tick)
    );

    modclk_divcore u_core (
        .clk      (clk),
        .rst      (rst),
        .cfg      (cfg),
        .tick     (tick),
        .sel_use  (sel_use),
        .clk_out  (clk_out),
        .rise_stb (rise_stb)
    );

endmodule

// File: tb/tb_modclk_div.sv
module tb_modclk_div;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [3:0]  ref_tick = '0;
    logic        clk_out;
    logic        rise_stb;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Vector table: source, exponent, divisor code, expected high and low tick counts
    localparam int NV = 8;
    localparam int V_SEL [NV] = '{0, 1, 2, 3, 0, 1, 2, 3};
    localparam int V_P   [NV] = '{0, 0, 1, 3, 2, 0, 3, 1};
    localparam int V_M   [NV] = '{0, 4, 2, 15, 6, 15, 0, 4};
    localparam int V_HI  [NV] = '{1, 3, 3, 64, 14, 8, 4, 5};
    localparam int V_LO  [NV] = '{0, 2, 3, 64, 14, 8, 4, 5};

    modclk_div #(.SEL_W(2)) dut (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .ref_tick (ref_tick),
        .clk_out  (clk_out),
        .rise_stb (rise_stb)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic [3:0] tk);
        @(negedge clk);
        ref_tick = tk;
        @(posedge clk);
        #1;
        ref_tick = '0;
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    function automatic logic [31:0] word(input int en, input int s, input int p, input int m);
        return (32'(en) << 31) | (32'(s) << 24) | (32'(p) << 16) | 32'(m);
    endfunction

    // One selected tick, then one cycle of ticks on every other source
    task automatic tick_sel(input int s, output logic o, output logic st, output logic noise_bad);
        logic [3:0] one;
        one = 4'(1) << s;
        cyc(one);
        o  = clk_out;
        st = rise_stb;
        cyc(~one);
        noise_bad = (clk_out !== o) || (rise_stb !== 1'b0);
    endtask

    task automatic settle();
        wr(32'h0);
        for (int i = 0; i < 300 && clk_out; i++) cyc(4'hF);
        cyc(4'h0);
        cyc(4'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic o, st, nb;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;

        // R1 reset state
        chk("R1 rd_data", rd_data, 32'h0);
        chk("R1 clk_out", 32'(clk_out), 32'h0);
        chk("R1 rise_stb", 32'(rise_stb), 32'h0);

        // R2 readback and unassigned bits
        wr(32'h7FFF_FFFF);
        chk("R2 readback all-ones", rd_data, 32'h0303_000F);
        wr(32'hA5A5_5A5A);
        chk("R2 readback pattern", rd_data, 32'h8101_000A);
        settle();
        chk("R2 readback zero", rd_data, 32'h0);

        // R3 R4 R5 R8 R9: table walk
        for (int v = 0; v < NV; v++) begin
            int n, e_out, e_stb, e_noise;
            n = V_HI[v] + V_LO[v];
            e_out = 0; e_stb = 0; e_noise = 0;
            settle();
            wr(word(1, V_SEL[v], V_P[v], V_M[v]));
            for (int k = 0; k < 2 * n; k++) begin
                tick_sel(V_SEL[v], o, st, nb);
                if (o !== ((k % n) < V_HI[v])) e_out++;
                if (st !== ((k % n) == 0)) e_stb++;
                if (nb) e_noise++;
            end
            chk($sformatf("R3 R4 R9 level pattern vec%0d", v), 32'(e_out), 32'h0);
            chk($sformatf("R8 strobe pattern vec%0d", v), 32'(e_stb), 32'h0);
            chk($sformatf("R5 other sources ignored vec%0d", v), 32'(e_noise), 32'h0);
        end

        // R6: ratio change mid-period takes effect at the next start
        begin
            logic exp_o [8] = '{1, 1, 0, 0, 1, 0, 1, 0};
            logic exp_s [8] = '{1, 0, 0, 0, 1, 0, 1, 0};
            settle();
            wr(word(1, 0, 0, 3));
            for (int k = 0; k < 8; k++) begin
                tick_sel(0, o, st, nb);
                chk($sformatf("R6 reload level tick%0d", k), 32'(o), 32'(exp_o[k]));
                chk($sformatf("R6 reload strobe tick%0d", k), 32'(st), 32'(exp_s[k]));
                if (k == 1) wr(word(1, 0, 0, 1));
            end
        end

        // R6 R5: source change applies at the boundary only
        settle();
        wr(word(1, 0, 0, 1));
        cyc(4'b0001);
        chk("R9 start on src0", 32'(clk_out), 32'h1);
        cyc(4'b0001);
        chk("R4 low half src0", 32'(clk_out), 32'h0);
        wr(word(1, 1, 0, 1));
        cyc(4'b0001);
        chk("R6 old source finishes period", 32'(clk_out), 32'h1);
        chk("R6 boundary strobe", 32'(rise_stb), 32'h1);
        cyc(4'b0001);
        chk("R5 old source now ignored", 32'(clk_out), 32'h1);
        cyc(4'b0010);
        chk("R5 new source advances", 32'(clk_out), 32'h0);

        // R7: disable while high finishes the high phase
        settle();
        wr(word(1, 2, 0, 7));
        cyc(4'b0100);
        cyc(4'b0100);
        wr(word(0, 2, 0, 7));
        cyc(4'b0100);
        chk("R7 high continues tick2", 32'(clk_out), 32'h1);
        cyc(4'b0100);
        chk("R7 high continues tick3", 32'(clk_out), 32'h1);
        cyc(4'b0100);
        chk("R7 low after high phase", 32'(clk_out), 32'h0);
        begin
            int seen = 0;
            for (int k = 0; k < 10; k++) begin
                cyc(4'b0100);
                if (clk_out || rise_stb) seen++;
            end
            chk("R7 stays low when stopped", 32'(seen), 32'h0);
        end

        // R9 restart, then R7 disable during the low phase resets the count
        wr(word(1, 2, 0, 7));
        cyc(4'b0100);
        chk("R9 restart level", 32'(clk_out), 32'h1);
        chk("R9 restart strobe", 32'(rise_stb), 32'h1);
        for (int k = 1; k < 6; k++) cyc(4'b0100);
        chk("R4 low at tick5", 32'(clk_out), 32'h0);
        wr(word(0, 2, 0, 7));
        cyc(4'h0);
        cyc(4'h0);
        wr(word(1, 2, 0, 7));
        cyc(4'b0100);
        chk("R7 fresh period after low-phase stop", 32'(clk_out), 32'h1);
        chk("R7 fresh strobe after low-phase stop", 32'(rise_stb), 32'h1);
        cyc(4'h0);
        chk("R8 strobe lasts one cycle", 32'(rise_stb), 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule